// File: doc/BRIEF.md
# Reset Sequencer

This block collects four reset requests and turns them into one chip-wide reset pulse. The four requests are power-on, brown-out, watchdog and an external pin, and all of them are active-low. Power-on and the filtered external pin share one path. Brown-out has a path of its own. A high-to-low transition on either path starts a reset pulse of fixed length. A low level on the watchdog request starts the same pulse, and it keeps reloading the pulse for as long as the request stays low.

The external pin only counts once it has stayed low for a programmable number of consecutive cycles. Shorter dips are discarded. While the pulse is high, a companion output forces every I/O direction and data register back to its default, which makes all pins high-impedance inputs. When the pulse ends, a start-up counter keeps the core clock enable low for a programmable number of cycles and then raises it. A new request that arrives during a pulse restarts the pulse length.

Top module: `rst_seq_ctrl`

## Requirements
- R1: While rst_ni is low, gbl_rst_o, io_rst_o and clk_run_o are all 0.
- R2: When por_n_i falls while the external path is inactive, gbl_rst_o is high for exactly PULSE_CYC cycles, starting right after the clock edge that first samples the low level.
- R3: When bor_n_i falls, gbl_rst_o is high for exactly PULSE_CYC cycles, starting right after the clock edge that first samples the low level.
- R4: Holding por_n_i or bor_n_i low for many cycles produces one pulse only, because those paths fire on the transition and not on the level.
- R5: ext_n_i must be sampled low on EXT_MIN_CYC consecutive clock edges before it takes effect; the pulse then begins after the next edge. A shorter low period has no effect on any output.
- R6: Every clock edge that samples wdt_n_i low reloads the pulse, so gbl_rst_o ends PULSE_CYC cycles after the last such edge.
- R7: A trigger that arrives during a pulse restarts the pulse count from PULSE_CYC.
- R8: io_rst_o is high in exactly the cycles in which gbl_rst_o is high.
- R9: clk_run_o is low while gbl_rst_o is high. It rises START_CYC clock edges after gbl_rst_o falls, and START_CYC clock edges after rst_ni is released.
- R10: The transition detectors start out at the inactive (high) level, so inputs that are high at release cause no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| por_n_i | input | 1 | Power-on request, active low |
| bor_n_i | input | 1 | Brown-out request, active low |
| wdt_n_i | input | 1 | Watchdog request, active low, level-sensitive |
| ext_n_i | input | 1 | External pin request, active low, glitch-filtered |
| gbl_rst_o | output | 1 | Global reset pulse, active high |
| io_rst_o | output | 1 | I/O register reset, active high |
| clk_run_o | output | 1 | Core clock enable |

## Verification
The hardest case to reach is the exact boundary of the external filter. The pin has to be held low for exactly EXT_MIN_CYC edges, and the filtered level has to be caught on the one edge after the pin has already gone high again. The stimulus table drives the pin low for one edge fewer than the threshold, for exactly the threshold, and for far longer. It records the first cycle of the pulse and its length each time. Retriggering is reached by releasing and reasserting the watchdog request part way through a pulse, and the bench checks that the pulse is stretched by exactly the gap.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  localparam int unsigned NUM_PATHS = 2;  // 0: power-on/external, 1: brown-out

  typedef struct packed {
    logic wdt;
    logic [NUM_PATHS-1:0] fall;
  } trig_t;
endpackage

// File: rtl/rst_ext_filter.sv
module rst_ext_filter #(
  parameter int unsigned MIN_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_n_i,
  output logic valid_n_o
);
  localparam int unsigned CW = $clog2(MIN_CYC + 1);
  localparam logic [CW-1:0] CMAX = CW'(MIN_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (pin_n_i)     cnt_q <= '0;
    else if (cnt_q != CMAX) cnt_q <= cnt_q + 1'b1;
  end

  assign valid_n_o = (cnt_q != CMAX);
endmodule

// File: rtl/rst_fall_det.sv
module rst_fall_det #(
  parameter int unsigned NP = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NP-1:0] lvl_i,
  output logic [NP-1:0] fall_o
);
  logic [NP-1:0] hist_q;

  for (genvar i = 0; i < NP; i++) begin : g_path
    // history presets high so a quiet input never fires at release
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) hist_q[i] <= 1'b1;
      else         hist_q[i] <= lvl_i[i];
    end
    assign fall_o[i] = hist_q[i] & ~lvl_i[i];
  end
endmodule

// File: rtl/rst_pulse_gen.sv
module rst_pulse_gen #(
  parameter int unsigned PULSE_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic pulse_o
);
  localparam int unsigned CW = $clog2(PULSE_CYC + 1);
  localparam logic [CW-1:0] RELOAD = CW'(PULSE_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else if (trig_i) begin
      cnt_q   <= RELOAD;
      pulse_q <= 1'b1;
    end else if (pulse_q) begin
      if (cnt_q == '0) pulse_q <= 1'b0;
      else             cnt_q   <= cnt_q - 1'b1;
    end
  end

  assign pulse_o = pulse_q;
endmodule

// File: rtl/rst_startup_delay.sv
module rst_startup_delay #(
  parameter int unsigned START_CYC = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  output logic run_o
);
  localparam int unsigned CW = $clog2(START_CYC + 1);
  localparam logic [CW-1:0] TERM = CW'(START_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (hold_i)        cnt_q <= '0;
    else if (cnt_q != TERM) cnt_q <= cnt_q + 1'b1;
  end

  // gate with hold so a fresh pulse drops the enable at once
  assign run_o = (cnt_q == TERM) && !hold_i;
endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rst_seq_pkg::*;
#(
  parameter int unsigned EXT_MIN_CYC = 16,
  parameter int unsigned PULSE_CYC   = 8,
  parameter int unsigned START_CYC   = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic por_n_i,
  input  logic bor_n_i,
  input  logic wdt_n_i,
  input  logic ext_n_i,
  output logic gbl_rst_o,
  output logic io_rst_o,
  output logic clk_run_o
);
  logic                 ext_ok_n;
  logic [NUM_PATHS-1:0] path_lvl;
  trig_t                trig;
  logic                 trig_any;
  logic                 pulse;

  rst_ext_filter #(.MIN_CYC(EXT_MIN_CYC)) u_ext_filter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pin_n_i   (ext_n_i),
    .valid_n_o (ext_ok_n)
  );

  assign path_lvl[0] = por_n_i & ext_ok_n;
  assign path_lvl[1] = bor_n_i;

  rst_fall_det #(.NP(NUM_PATHS)) u_fall_det (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (path_lvl),
    .fall_o (trig.fall)
  );

  assign trig.wdt = ~wdt_n_i;
  assign trig_any = trig.wdt | (|trig.fall);

  rst_pulse_gen #(.PULSE_CYC(PULSE_CYC)) u_pulse_gen (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .trig_i  (trig_any),
    .pulse_o (pulse)
  );

  rst_startup_delay #(.START_CYC(START_CYC)) u_startup (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hold_i (pulse),
    .run_o  (clk_run_o)
  );

  assign gbl_rst_o = pulse;
  assign io_rst_o  = pulse;
endmodule

// File: rtl/rst_seq_chk.sv
module rst_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic por_n_i,
  input logic bor_n_i,
  input logic wdt_n_i,
  input logic ext_n_i,
  input logic gbl_rst_o,
  input logic clk_run_o
);
  logic bor_h_q, por_h_q, ext_h_q, gbl_h_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bor_h_q <= 1'b1;
      por_h_q <= 1'b1;
      ext_h_q <= 1'b1;
      gbl_h_q <= 1'b0;
    end else begin
      bor_h_q <= bor_n_i;
      por_h_q <= por_n_i;
      ext_h_q <= ext_n_i;
      gbl_h_q <= gbl_rst_o;
    end
  end

  assert_bor_fire_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bor_h_q && !bor_n_i) |=> gbl_rst_o);

  assert_por_fire_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (por_h_q && !por_n_i && ext_h_q && ext_n_i) |=> gbl_rst_o);

  assert_wdt_fire_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wdt_n_i |=> gbl_rst_o);

  assert_run_after_fall_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gbl_h_q && !gbl_rst_o) |-> !clk_run_o);

  assert_run_rise_gap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_run_o) |-> (!gbl_rst_o && !gbl_h_q));
endmodule

bind rst_seq_ctrl rst_seq_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .por_n_i   (por_n_i),
  .bor_n_i   (bor_n_i),
  .wdt_n_i   (wdt_n_i),
  .ext_n_i   (ext_n_i),
  .gbl_rst_o (gbl_rst_o),
  .clk_run_o (clk_run_o)
);

// File: tb/rst_seq_ctrl_tb.sv
module rst_seq_ctrl_tb;
  localparam int EXT_MIN = 16;
  localparam int PULSE   = 8;
  localparam int START   = 12;
  localparam int WIN     = 70;
  localparam int NVEC    = 9;

  // src: 0 por, 1 bor, 2 wdt, 3 ext; len 0 = no pulse expected
  typedef struct packed {
    logic [1:0] src;
    int         dur;
    int         len;
    int         first;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 1,  PULSE, 0},           // R2
    '{2'd1, 1,  PULSE, 0},           // R3
    '{2'd0, 30, PULSE, 0},           // R4
    '{2'd1, 30, PULSE, 0},           // R4
    '{2'd3, EXT_MIN-1, 0, 0},        // R5 short
    '{2'd3, EXT_MIN, PULSE, EXT_MIN},// R5 boundary
    '{2'd3, 40, PULSE, EXT_MIN},     // R5 long
    '{2'd2, 1,  PULSE, 0},           // R6
    '{2'd2, 5,  PULSE+4, 0}          // R6
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic por_n = 1'b1, bor_n = 1'b1, wdt_n = 1'b1, ext_n = 1'b1;
  logic gbl, iorst, run;

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rst_seq_ctrl #(.EXT_MIN_CYC(EXT_MIN), .PULSE_CYC(PULSE), .START_CYC(START)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .por_n_i(por_n), .bor_n_i(bor_n),
    .wdt_n_i(wdt_n), .ext_n_i(ext_n),
    .gbl_rst_o(gbl), .io_rst_o(iorst), .clk_run_o(run)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_src(input logic [1:0] s, input logic v);
    case (s)
      2'd0: por_n = v;
      2'd1: bor_n = v;
      2'd2: wdt_n = v;
      default: ext_n = v;
    endcase
  endtask

  int hi_cnt, first_hi, last_hi, first_run, io_bad, run_low;

  // observes WIN cycles; called at a negedge with stimulus already applied
  task automatic observe(input logic [1:0] s, input int dur, input int re_at);
    hi_cnt = 0; first_hi = -1; last_hi = -1; first_run = -1; io_bad = 0; run_low = 0;
    for (int i = 0; i < WIN; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (gbl) begin
        hi_cnt++;
        if (first_hi < 0) first_hi = i;
        last_hi = i;
        if (run) run_low++;  // enable must be low during pulse
      end
      if (!run && !gbl && last_hi < 0) run_low++;
      if (run && last_hi >= 0 && first_run < 0) first_run = i;
      if (iorst != gbl) io_bad++;
      if (i + 1 == dur) set_src(s, 1'b1);
      if (re_at > 0 && i + 1 == re_at) set_src(s, 1'b0);
      if (re_at > 0 && i == re_at) set_src(s, 1'b1);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 gbl in reset", int'(gbl), 0);
    chk("R1 io in reset", int'(iorst), 0);
    chk("R1 run in reset", int'(run), 0);
    rst_n = 1'b1;
    repeat (START - 1) begin @(posedge clk); @(negedge clk); end
    chk("R9 run before start delay", int'(run), 0);
    chk("R10 no pulse after release", int'(gbl), 0);
    @(posedge clk); @(negedge clk);
    chk("R9 run after start delay", int'(run), 1);

    for (int v = 0; v < NVEC; v++) begin
      set_src(VECS[v].src, 1'b0);
      observe(VECS[v].src, VECS[v].dur, 0);
      if (VECS[v].len == 0) begin
        chk("R5 short ext pulse length", hi_cnt, 0);
        chk("R5 short ext run stays high", run_low, 0);
      end else begin
        chk($sformatf("R2/R3/R5/R6 vec%0d pulse length", v), hi_cnt, VECS[v].len);
        chk($sformatf("R2/R3/R5/R6 vec%0d pulse start", v), first_hi, VECS[v].first);
        chk($sformatf("R9 vec%0d start delay", v), first_run - last_hi, START + 1);
        chk($sformatf("R9 vec%0d run low in pulse", v), run_low, 0);
      end
      chk($sformatf("R8 vec%0d io follows gbl", v), io_bad, 0);
    end

    // R7: watchdog pulses at edge 0 and edge 4
    wdt_n = 1'b0;
    observe(2'd2, 1, 4);
    chk("R7 retrigger length", hi_cnt, PULSE + 4);
    chk("R7 retrigger start", first_hi, 0);
    chk("R8 retrigger io", io_bad, 0);

    // R2 R3 together: single pulse
    por_n = 1'b0; bor_n = 1'b0;
    observe(2'd0, 1, 0);
    bor_n = 1'b1;
    chk("R2 R3 simultaneous length", hi_cnt, PULSE);
    chk("R9 simultaneous delay", first_run - last_hi, START + 1);

    // R1: async reset in mid pulse clears outputs
    wdt_n = 1'b0;
    @(posedge clk); @(negedge clk);
    wdt_n = 1'b1;
    chk("R6 pulse before reset", int'(gbl), 1);
    rst_n = 1'b0;
    #1;
    chk("R1 gbl cleared async", int'(gbl), 0);
    chk("R1 run cleared async", int'(run), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) begin @(posedge clk); @(negedge clk); end
    chk("R10 no pulse after re-release", int'(gbl), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule